// File: doc/BRIEF.md
# Receive FIFO with timeout interrupt

This block sits behind a serial receiver. It buffers up to 128 received characters. Each character is held as a data byte together with three error tag bits. A one-cycle character-valid pulse from the receiver pushes the byte and its tags. The oldest entry is always visible on the holding outputs. When the host issues a read strobe, that entry is consumed, and the holding data and tags switch to the next entry in the following cycle.

Two interrupt sources are produced. The first is a data-ready request. It asserts either whenever anything is buffered, or only once the occupancy reaches a programmable trigger level. The second is a timeout request. It fires when characters are waiting in the buffer and no character has arrived and no read has happened for four character frames plus twelve bit times. That interval is measured in ticks of the 16x oversampling clock enable, and the frame length follows the current word-length code. A single interrupt enable gates both requests.

If a character arrives while the buffer is full and no read frees a slot, the character is dropped and a sticky overrun flag is raised.

Top module: `rx_fifo_tmo`

## Requirements
- R1: Each `char_vld` pulse stores one entry when the buffer holds fewer than 128 entries. `fill_cnt` reports the stored count one cycle later, and never exceeds 128.
- R2: `hold_data` and `hold_tags` show the oldest entry. A `host_rd` strobe on a non-empty buffer removes that entry, and the next cycle shows the following entry's byte and tags. While the buffer is empty, both outputs read 0 and `host_rd` changes no content.
- R3: A `char_vld` while the buffer holds 128 entries and `host_rd` is low is dropped, leaving the contents unchanged, and `overrun` is 1 from the next cycle. `overrun` stays set until a cycle after a `host_rd` strobe. A push and a pop in the same cycle on a full buffer are both accepted.
- R4: `ready_irq` is `rx_int_en` AND a threshold test on `fill_cnt`. With `trig_mode`=0 the threshold is 1. With `trig_mode`=1 the threshold is `trig_lvl`, and a `trig_lvl` of 0 acts as 1.
- R5: The timeout limit in `tick16` ticks is (4×(N+2)+12)×16, where N = 5 + `wlen_code`. This gives 640, 704, 768 and 832 ticks for codes 0 to 3.
- R6: The timeout counter advances only on `tick16` while the buffer is non-empty. It restarts on any `char_vld` or `host_rd`, and a restart takes priority over a tick. The timeout flag sets at the clock edge that takes the limit-th tick. `tmo_irq` is the flag AND `rx_int_en`, and clearing the enable does not erase the flag.
- R7: The timeout flag clears one cycle after a `host_rd` strobe, or when the buffer is empty. An arriving character does not clear it.
- R8: After reset the buffer is empty, `data_avail`, `overrun`, `ready_irq` and `tmo_irq` are 0, and `data_avail` equals (`fill_cnt` ≠ 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_vld | input | 1 | One-cycle pulse: a received character is offered |
| char_data | input | 8 | Received byte |
| char_tags | input | 3 | Error tags of the received byte |
| host_rd | input | 1 | Host read strobe of the holding outputs |
| tick16 | input | 1 | 16x oversampling clock enable |
| wlen_code | input | 2 | Data bits per character minus 5 |
| trig_mode | input | 1 | 0: request on any data, 1: request at trigger level |
| trig_lvl | input | 8 | Trigger occupancy level |
| rx_int_en | input | 1 | Receive interrupt enable |
| hold_data | output | 8 | Byte of the oldest entry (0 if empty) |
| hold_tags | output | 3 | Tags of the oldest entry (0 if empty) |
| fill_cnt | output | 8 | Number of stored entries |
| data_avail | output | 1 | Buffer is non-empty |
| ready_irq | output | 1 | Data-ready interrupt request |
| tmo_irq | output | 1 | Timeout interrupt request |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
Storage, holding outputs, overrun and the timeout flag are registered, so each takes effect one clock after the rising edge that samples the stimulus. `ready_irq` and the enable gating of `tmo_irq` follow the configuration inputs within the same cycle. The bench applies every stimulus on a falling edge, and a behavioural model consumes it at the same rising edge as the design. All outputs are then compared at the next falling edge, which is exactly where each registered result is due. The timeout checks count `tick16` edges from the first stored character and expect the flag to be clear after one tick less than the limit and set after exactly the limit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W     = 8;
  localparam int TAG_W      = 3;
  localparam int BASE_BITS  = 5;   // data bits for word-length code 0
  localparam int FRAME_OVH  = 2;   // start + stop bits
  localparam int TMO_WORDS  = 4;
  localparam int TMO_EXTRA  = 12;
  localparam int OVERSAMPLE = 16;
  localparam int TMO_MAX    = (TMO_WORDS * (BASE_BITS + 3 + FRAME_OVH) + TMO_EXTRA) * OVERSAMPLE;
  localparam int TMO_W      = $clog2(TMO_MAX + 1);

  typedef logic [1:0] wlen_t;

  function automatic logic [TMO_W-1:0] tmo_ticks(input wlen_t code);
    int bits;
    bits = BASE_BITS + int'(code);
    return TMO_W'((TMO_WORDS * (bits + FRAME_OVH) + TMO_EXTRA) * OVERSAMPLE);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int TW    = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic [TW-1:0] push_tags,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic [TW-1:0] head_tags,
  output logic [CW-1:0] fill,
  output logic          overrun
);
  localparam int EW = DW + TW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, rd_ptr_nxt;
  logic [AW-1:0] wr_ptr, wr_ptr_nxt;
  logic [CW-1:0] fill_q, fill_nxt;
  logic          ovr_q, ovr_nxt;
  logic          empty, full, pop_en, wr_en;
  logic [EW-1:0] head_ent;

  always_comb begin
    empty  = (fill_q == '0);
    full   = (fill_q == CW'(DEPTH));
    pop_en = pop_req && !empty;
    wr_en  = push_req && (!full || pop_en);

    rd_ptr_nxt = rd_ptr;
    if (pop_en) rd_ptr_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);

    wr_ptr_nxt = wr_ptr;
    if (wr_en) wr_ptr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);

    fill_nxt = fill_q;
    if (wr_en && !pop_en)      fill_nxt = fill_q + CW'(1);
    else if (pop_en && !wr_en) fill_nxt = fill_q - CW'(1);

    ovr_nxt = ovr_q;
    if (push_req && full && !pop_req) ovr_nxt = 1'b1;
    else if (pop_req)                 ovr_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      wr_ptr <= wr_ptr_nxt;
      fill_q <= fill_nxt;
      ovr_q  <= ovr_nxt;
    end
  end

  // storage array: written only through the write enable, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {push_tags, push_data};
  end

  always_comb begin
    head_ent  = mem[rd_ptr];
    head_data = empty ? '0 : head_ent[DW-1:0];
    head_tags = empty ? '0 : head_ent[EW-1:DW];
  end

  assign fill    = fill_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          rd_clr,
  input  logic          has_data,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_nxt, cnt_inc;
  logic          flag_q, flag_nxt, hit;

  always_comb begin
    cnt_inc = cnt_q + TW'(1);
    hit     = (cnt_inc >= limit);

    cnt_nxt = cnt_q;
    if (!has_data || restart)  cnt_nxt = '0;
    else if (tick && !flag_q)  cnt_nxt = hit ? '0 : cnt_inc;

    flag_nxt = flag_q;
    if (!has_data || rd_clr)                       flag_nxt = 1'b0;
    else if (!restart && tick && !flag_q && hit)   flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign expired = flag_q;
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] trig_lvl,
  input  logic          trig_mode,
  input  logic          int_en,
  input  logic          tmo_flag,
  output logic          ready_irq,
  output logic          tmo_irq
);
  logic [CW-1:0] eff_lvl, threshold;

  always_comb begin
    eff_lvl   = (trig_lvl == '0) ? CW'(1) : trig_lvl;
    threshold = trig_mode ? eff_lvl : CW'(1);
    ready_irq = int_en && (fill >= threshold);
    tmo_irq   = int_en && tmo_flag;
  end
endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo #(
  parameter int DEPTH = 128,
  parameter int DW    = rxq_pkg::DATA_W,
  parameter int TW    = rxq_pkg::TAG_W,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_vld,
  input  logic [DW-1:0] char_data,
  input  logic [TW-1:0] char_tags,
  input  logic          host_rd,
  input  logic          tick16,
  input  logic [1:0]    wlen_code,
  input  logic          trig_mode,
  input  logic [CW-1:0] trig_lvl,
  input  logic          rx_int_en,
  output logic [DW-1:0] hold_data,
  output logic [TW-1:0] hold_tags,
  output logic [CW-1:0] fill_cnt,
  output logic          data_avail,
  output logic          ready_irq,
  output logic          tmo_irq,
  output logic          overrun
);
  import rxq_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [CW-1:0]    fill_w;
  logic             tmo_flag;
  logic [TMO_W-1:0] tmo_limit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign tmo_limit = tmo_ticks(wlen_code);

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push_req  (char_vld),
    .push_data (char_data),
    .push_tags (char_tags),
    .pop_req   (host_rd),
    .head_data (hold_data),
    .head_tags (hold_tags),
    .fill      (fill_w),
    .overrun   (overrun)
  );

  rxq_timer #(.TW(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick16),
    .restart  (char_vld || host_rd),
    .rd_clr   (host_rd),
    .has_data (fill_w != '0),
    .limit    (tmo_limit),
    .expired  (tmo_flag)
  );

  rxq_irq #(.CW(CW)) u_irq (
    .fill      (fill_w),
    .trig_lvl  (trig_lvl),
    .trig_mode (trig_mode),
    .int_en    (rx_int_en),
    .tmo_flag  (tmo_flag),
    .ready_irq (ready_irq),
    .tmo_irq   (tmo_irq)
  );

  assign fill_cnt   = fill_w;
  assign data_avail = (fill_w != '0);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_vld,
  input logic          host_rd,
  input logic [CW-1:0] fill_cnt,
  input logic          overrun,
  input logic          tmo_irq
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R1

  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !char_vld && fill_cnt != '0) |=> fill_cnt == $past(fill_cnt) - CW'(1)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && !host_rd && fill_cnt == CW'(DEPTH)) |=> (overrun && fill_cnt == CW'(DEPTH))); // R3

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> fill_cnt != '0); // R6

  AST_TMO_CLR_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !tmo_irq); // R7
endmodule

bind rx_fifo_tmo rxq_checker #(.DEPTH(DEPTH), .CW(CW)) u_rxq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .char_vld (char_vld),
  .host_rd  (host_rd),
  .fill_cnt (fill_cnt),
  .overrun  (overrun),
  .tmo_irq  (tmo_irq)
);

// File: tb/rx_fifo_tmo_bench.sv
`timescale 1ns/1ps
module rx_fifo_tmo_bench;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv = 1'b0, rd = 1'b0, tk = 1'b0, tm = 1'b0, en = 1'b0;
  logic [7:0] cd = '0;
  logic [2:0] ct = '0;
  logic [1:0] wl = '0;
  logic [7:0] tl = '0;

  logic [7:0] hold_data;
  logic [2:0] hold_tags;
  logic [7:0] fill_cnt;
  logic       data_avail, ready_irq, tmo_irq, overrun;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [10:0] mq[$];
  int  m_tcnt = 0;
  bit  m_flag = 0;
  bit  m_ovr  = 0;

  always #2.5 clk = ~clk;

  rx_fifo_tmo u_rx_fifo_tmo (
    .clk(clk), .rst_n(rst_n), .char_vld(cv), .char_data(cd), .char_tags(ct),
    .host_rd(rd), .tick16(tk), .wlen_code(wl), .trig_mode(tm), .trig_lvl(tl),
    .rx_int_en(en), .hold_data(hold_data), .hold_tags(hold_tags),
    .fill_cnt(fill_cnt), .data_avail(data_avail), .ready_irq(ready_irq),
    .tmo_irq(tmo_irq), .overrun(overrun)
  );

  function automatic int lim_of(input int code);
    return (4 * ((5 + code) + 2) + 12) * 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_tcnt = 0; m_flag = 0; m_ovr = 0;
    end else begin
      int  sz;
      bit  has, popd, pushd, rst_t, hit;
      sz    = mq.size();
      has   = (sz != 0);
      popd  = rd && has;
      pushd = cv && (sz < DEPTH || popd);
      rst_t = cv || rd;
      hit   = (m_tcnt + 1) >= lim_of(int'(wl));
      // timeout flag and counter
      if (!has || rd) m_flag = 0;
      else if (!rst_t && tk && !m_flag && hit) m_flag = 1;
      if (!has || rst_t) m_tcnt = 0;
      else if (tk && (m_flag == 0 || hit)) m_tcnt = hit ? 0 : m_tcnt + 1;
      // overrun
      if (cv && sz == DEPTH && !rd) m_ovr = 1;
      else if (rd) m_ovr = 0;
      if (popd)  void'(mq.pop_front());
      if (pushd) mq.push_back({ct, cd});
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz, thr, e_rdy;
    sz  = mq.size();
    thr = tm ? ((tl == 0) ? 1 : int'(tl)) : 1;
    e_rdy = (en && sz >= thr) ? 1 : 0;
    check("R1", "fill_cnt", int'(fill_cnt), sz);
    check("R2", "hold_data", int'(hold_data), sz != 0 ? int'(mq[0][7:0]) : 0);
    check("R2", "hold_tags", int'(hold_tags), sz != 0 ? int'(mq[0][10:8]) : 0);
    check("R8", "data_avail", int'(data_avail), sz != 0 ? 1 : 0);
    check("R4", "ready_irq", int'(ready_irq), e_rdy);
    check("R6", "tmo_irq", int'(tmo_irq), (en && m_flag) ? 1 : 0);
    check("R3", "overrun", int'(overrun), int'(m_ovr));
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input logic [2:0] t,
                     input bit r, input bit k);
    cv = v; cd = d; ct = t; rd = r; tk = k;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n, input bit k);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'd0, 0, k);
  endtask

  task automatic drain();
    while (mq.size() != 0) cyc(0, 8'h00, 3'd0, 1, 0);
    cyc(0, 8'h00, 3'd0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4, 0);
    // R8: reset state
    check("R8", "reset fill_cnt", int'(fill_cnt), 0);
    check("R8", "reset data_avail", int'(data_avail), 0);
    check("R8", "reset overrun", int'(overrun), 0);
    check("R8", "reset tmo_irq", int'(tmo_irq), 0);

    // R2: head entry and tags after pops
    en = 1; tm = 0;
    cyc(1, 8'hA1, 3'd1, 0, 0);
    cyc(1, 8'h52, 3'd2, 0, 0);
    cyc(1, 8'h33, 3'd4, 0, 0);
    check("R2", "head byte", int'(hold_data), 8'hA1);
    check("R4", "per-char ready", int'(ready_irq), 1);
    cyc(0, 8'h00, 3'd0, 1, 0);
    check("R2", "next head byte", int'(hold_data), 8'h52);
    check("R2", "next head tags", int'(hold_tags), 2);
    cyc(0, 8'h00, 3'd0, 1, 0);
    cyc(0, 8'h00, 3'd0, 1, 0);
    check("R2", "empty byte reads 0", int'(hold_data), 0);
    cyc(0, 8'h00, 3'd0, 1, 0);
    check("R2", "read on empty keeps count", int'(fill_cnt), 0);

    // R1/R3: fill to capacity, overflow, full push+pop
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 8'(i), 3'(i % 8), 0, 0);
    check("R1", "full count", int'(fill_cnt), DEPTH);
    check("R3", "overrun set", int'(overrun), 1);
    check("R3", "head unchanged on drop", int'(hold_data), 0);
    cyc(0, 8'h00, 3'd0, 0, 0);
    check("R3", "overrun sticky", int'(overrun), 1);
    cyc(1, 8'hEE, 3'd5, 1, 0);
    check("R3", "push+pop full count", int'(fill_cnt), DEPTH);
    check("R3", "push+pop full head", int'(hold_data), 1);
    check("R3", "overrun cleared by read", int'(overrun), 0);
    drain();

    // R4: trigger-level mode
    tm = 1; tl = 8'd4;
    for (int i = 0; i < 3; i++) cyc(1, 8'(8'h10 + i), 3'd0, 0, 0);
    check("R4", "below trigger", int'(ready_irq), 0);
    cyc(1, 8'h13, 3'd0, 0, 0);
    check("R4", "at trigger", int'(ready_irq), 1);
    en = 0; cyc(0, 8'h00, 3'd0, 0, 0);
    check("R4", "gated by enable", int'(ready_irq), 0);
    en = 1; tl = 8'd0; cyc(0, 8'h00, 3'd0, 0, 0);
    check("R4", "level 0 acts as 1", int'(ready_irq), 1);
    drain();
    tm = 0;

    // R5/R6/R7: timeout per word length
    for (int c = 0; c < 4; c++) begin
      wl = 2'(c);
      cyc(1, 8'(8'h40 + c), 3'd3, 0, 1);
      idle(lim_of(c) - 1, 1);
      check("R5", "no timeout before limit", int'(tmo_irq), 0);
      idle(1, 1);
      check("R5", "timeout at limit", int'(tmo_irq), 1);
      en = 0; cyc(0, 8'h00, 3'd0, 0, 0);
      check("R6", "timeout gated", int'(tmo_irq), 0);
      en = 1; cyc(0, 8'h00, 3'd0, 0, 0);
      check("R6", "flag kept while gated", int'(tmo_irq), 1);
      cyc(1, 8'h77, 3'd0, 0, 0);
      check("R7", "char keeps timeout", int'(tmo_irq), 1);
      cyc(0, 8'h00, 3'd0, 1, 0);
      check("R7", "read clears timeout", int'(tmo_irq), 0);
      drain();
    end

    // R6: restart on a new character
    wl = 2'd3;
    cyc(1, 8'h61, 3'd0, 0, 1);
    idle(500, 1);
    cyc(1, 8'h62, 3'd0, 0, 1);
    idle(lim_of(3) - 1, 1);
    check("R6", "restart delays timeout", int'(tmo_irq), 0);
    idle(1, 1);
    check("R6", "timeout after restart", int'(tmo_irq), 1);
    drain();

    // mixed traffic against the model
    for (int i = 0; i < 20000; i++) begin
      if (i % 700 == 0) begin
        wl = 2'($urandom_range(0, 3));
        tm = 1'($urandom_range(0, 1));
        tl = 8'($urandom_range(0, 8));
        en = ($urandom_range(0, 9) != 0);
      end
      cyc(($urandom_range(0, 99) < 30), 8'($urandom), 3'($urandom),
          ($urandom_range(0, 99) < 20), ($urandom_range(0, 99) < 60));
    end

    done = 1;
    finish_run();
  end
endmodule